// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This block keeps a table of object handles in an on-chip entry store. It serves four commands on one valid/ready request port: insert, lookup, remove and clear. A requester inserts a 32-bit handle together with a channel number, an engine selector and an instance address. It can later look the handle up for the same channel, or free a slot whose index it already holds. Each command ends with a one-cycle response that carries done, hit and fail flags, the slot index and a context word.

The start slot comes from an XOR fold of the handle, mixed with the channel number. Collisions are resolved by linear probing that wraps from the last slot to the first. Every slot holds two words, a handle word and a context word. The layout of the context word follows a format-select input, so one table image can serve an older or a newer consumer. A two-bit search-limit input bounds how many slots a lookup may visit.

Top module: `obj_hash_engine`

## Requirements
- R1: The start slot is the XOR of all HASH_BITS-wide chunks of the handle, taken upward from bit 0 with the top chunk zero-padded. The low HASH_BITS bits of (channel << (HASH_BITS-4)) are then XORed in. An insert into an empty table lands at this slot.
- R2: When the start slot is taken, insert moves to the next slot index, and it moves from the last slot to slot 0.
- R3: An insert that finds every slot occupied (handle word nonzero) reports fail and changes no entry.
- R4: A handle of zero is never stored and never found. Inserting it reports fail, and looking it up reports a miss.
- R5: With fmt_newer=0 the context word is {1'b1, 2'b0, channel[4:0], 6'b0, engine[1:0], inst[19:4]}. Bit 31 is the valid flag.
- R6: With fmt_newer=1 the context word is {4'b0, channel[4:0], 1'b0, engine[1:0], 4'b0, inst[19:4]}. The channel sits in bits 27:23 and the engine in bits 21:20.
- R7: A lookup hits only on a slot whose handle word equals the handle and whose context channel field (per the current format) equals the channel. The hit returns that slot and its context word. Reaching an empty slot ends the lookup as a miss.
- R8: A lookup visits at most 16 << search_lim slots (search_lim 3 allows 128) and also stops after a full wrap. A hit on the last allowed probe is still reported.
- R9: Remove zeroes both words of the given slot. A later lookup of that handle misses, and the slot is free for a new insert.
- R10: Clear zeroes every word, one word per cycle, and holds req_ready low while it runs. Its response appears 2*2^HASH_BITS+1 cycles after acceptance, and all earlier handles then miss.
- R11: req_op encodes 0 insert, 1 lookup, 2 remove, 3 clear. req_ready is high only when idle. Each accepted command yields exactly one single-cycle rsp_done, and rsp_hit and rsp_fail never appear together or without rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Block idle, command accepted on valid and ready |
| req_op | input | 2 | 0 insert, 1 lookup, 2 remove, 3 clear |
| req_handle | input | 32 | Object handle |
| req_chan | input | 5 | Channel number |
| req_engine | input | 2 | Engine selector for insert |
| req_inst | input | 20 | Instance byte address; bits 19:4 are stored |
| req_slot | input | HASH_BITS | Slot to remove |
| fmt_newer | input | 1 | Context word layout select |
| search_lim | input | 2 | Lookup probe limit code |
| rsp_done | output | 1 | Response valid for one cycle |
| rsp_hit | output | 1 | Lookup found the handle |
| rsp_fail | output | 1 | Insert could not store the handle |
| rsp_slot | output | HASH_BITS | Slot written or found |
| rsp_ctx | output | 32 | Context word written or found |

## Verification
The hardest conditions to reach are a completely full table and a probe chain long enough to meet the search limit. Random handles almost never collide often enough to build either one. The bench therefore uses a 32-slot table and builds handles whose chunks cancel in the fold, for example k | (k << 5), so that every one of them hashes to slot 0. Inserting 32 such handles fills slots 0 to 31 in order. This gives a fail on the 33rd insert, exact limit boundaries at probes 16 and 17, and a miss that ends only after a full wrap.

// File: rtl/ht_pkg.sv
// Shared types and layout constants for the handle hash table engine.
// Assumes a 5-bit channel number and a 32-bit word for both entry words.
package ht_pkg;
    localparam int WORD_W = 32;
    localparam int CHAN_W = 5;
    localparam int ENG_W  = 2;
    localparam int INST_W = 20;

    // Command encodings seen on req_op
    typedef enum logic [1:0] {
        OP_INSERT = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_REMOVE = 2'd2,
        OP_CLEAR  = 2'd3
    } ht_op_t;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROBE = 3'd1,
        ST_WR_H  = 3'd2,
        ST_WR_C  = 3'd3,
        ST_CLEAR = 3'd4
    } ht_state_t;

    // Field positions of the two context layouts
    localparam int LEG_CHAN_LSB = 24;
    localparam int LEG_ENG_LSB  = 16;
    localparam int LEG_VALID    = 31;
    localparam int NEW_CHAN_LSB = 23;
    localparam int NEW_ENG_LSB  = 20;
endpackage

// File: rtl/ht_hash.sv
// Start-slot hash: XOR fold of the handle in HASH_BITS chunks from bit 0,
// then the channel shifted by HASH_BITS-4 folded in, truncated to the slot width.
// Assumes HASH_BITS >= 4.
module ht_hash #(
    parameter int HASH_BITS = 9
) (
    input  logic [ht_pkg::WORD_W-1:0] handle,
    input  logic [ht_pkg::CHAN_W-1:0] chan,
    output logic [HASH_BITS-1:0]      slot
);
    localparam int NCHUNK = (ht_pkg::WORD_W + HASH_BITS - 1) / HASH_BITS;
    localparam int PAD_W  = NCHUNK * HASH_BITS;
    localparam int SHIFT  = HASH_BITS - 4;
    localparam int EXT_W  = HASH_BITS + ht_pkg::CHAN_W;

    logic [PAD_W-1:0] padded;
    logic [EXT_W-1:0] chan_ext;

    // Fold all chunks, then mix the shifted channel
    always_comb begin
        padded   = PAD_W'(handle);
        chan_ext = EXT_W'(chan) << SHIFT;
        slot     = chan_ext[HASH_BITS-1:0];
        for (int i = 0; i < NCHUNK; i++) begin
            slot = slot ^ padded[i*HASH_BITS +: HASH_BITS];
        end
    end
endmodule

// File: rtl/ht_ctx_fmt.sv
// Context word formatter: builds the context word for an insert and pulls
// the channel field out of a stored word, both in the selected layout.
module ht_ctx_fmt (
    input  logic                       fmt_newer,
    input  logic [ht_pkg::CHAN_W-1:0]  chan,
    input  logic [ht_pkg::ENG_W-1:0]   engine,
    input  logic [ht_pkg::INST_W-1:0]  inst,
    input  logic [ht_pkg::WORD_W-1:0]  stored,
    output logic [ht_pkg::WORD_W-1:0]  ctx_out,
    output logic [ht_pkg::CHAN_W-1:0]  stored_chan
);
    import ht_pkg::*;

    // Pack the new context word
    always_comb begin
        ctx_out       = '0;
        ctx_out[15:0] = inst[INST_W-1:4];
        if (fmt_newer) begin
            ctx_out[NEW_CHAN_LSB +: CHAN_W] = chan;
            ctx_out[NEW_ENG_LSB  +: ENG_W]  = engine;
        end else begin
            ctx_out[LEG_CHAN_LSB +: CHAN_W] = chan;
            ctx_out[LEG_ENG_LSB  +: ENG_W]  = engine;
            ctx_out[LEG_VALID]              = 1'b1;
        end
    end

    // Extract the channel of a stored word
    always_comb begin
        stored_chan = fmt_newer ? stored[NEW_CHAN_LSB +: CHAN_W]
                                : stored[LEG_CHAN_LSB +: CHAN_W];
    end
endmodule

// File: rtl/ht_store.sv
// Entry store: two words per slot (even address handle, odd address context),
// one synchronous write port and two asynchronous read ports for one slot.
// Contents are undefined until a clear command has run.
module ht_store #(
    parameter int HASH_BITS = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [HASH_BITS:0]        waddr,
    input  logic [ht_pkg::WORD_W-1:0] wdata,
    input  logic [HASH_BITS-1:0]      rslot,
    output logic [ht_pkg::WORD_W-1:0] rd_handle,
    output logic [ht_pkg::WORD_W-1:0] rd_ctx
);
    localparam int WORDS = 2 << HASH_BITS;

    logic [ht_pkg::WORD_W-1:0] mem [WORDS];

    // Single write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Both words of the probed slot
    always_comb begin
        rd_handle = mem[{rslot, 1'b0}];
        rd_ctx    = mem[{rslot, 1'b1}];
    end
endmodule

// File: rtl/obj_hash_engine.sv
// Handle hash table engine. Accepts one command at a time when idle,
// probes linearly from the hashed slot, writes entries one word per cycle,
// and returns a single-cycle response. Assumes HASH_BITS >= 4.
module obj_hash_engine #(
    parameter int HASH_BITS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [31:0]           req_handle,
    input  logic [4:0]            req_chan,
    input  logic [1:0]            req_engine,
    input  logic [19:0]           req_inst,
    input  logic [HASH_BITS-1:0]  req_slot,
    input  logic                  fmt_newer,
    input  logic [1:0]            search_lim,
    output logic                  rsp_done,
    output logic                  rsp_hit,
    output logic                  rsp_fail,
    output logic [HASH_BITS-1:0]  rsp_slot,
    output logic [31:0]           rsp_ctx
);
    import ht_pkg::*;

    localparam int WORDS   = 2 << HASH_BITS;
    localparam int CNT_W   = 8;
    localparam int ADDR_W  = HASH_BITS + 1;

    ht_state_t             st;
    ht_op_t                op_q;
    logic [WORD_W-1:0]     handle_q;
    logic [CHAN_W-1:0]     chan_q;
    logic [ENG_W-1:0]      eng_q;
    logic [INST_W-1:0]     inst_q;
    logic [HASH_BITS-1:0]  start_q, cur_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [ADDR_W-1:0]     clr_addr;

    logic [HASH_BITS-1:0]  hash_slot, nxt_slot;
    logic [WORD_W-1:0]     rd_handle, rd_ctx, new_ctx;
    logic [CHAN_W-1:0]     rd_chan;
    logic [CNT_W-1:0]      limit;
    logic                  we;
    logic [ADDR_W-1:0]     waddr;
    logic [WORD_W-1:0]     wdata;

    ht_hash #(.HASH_BITS(HASH_BITS)) u_hash (
        .handle (req_handle),
        .chan   (req_chan),
        .slot   (hash_slot)
    );

    ht_ctx_fmt u_fmt (
        .fmt_newer   (fmt_newer),
        .chan        (chan_q),
        .engine      (eng_q),
        .inst        (inst_q),
        .stored      (rd_ctx),
        .ctx_out     (new_ctx),
        .stored_chan (rd_chan)
    );

    ht_store #(.HASH_BITS(HASH_BITS)) u_store (
        .clk       (clk),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .rslot     (cur_q),
        .rd_handle (rd_handle),
        .rd_ctx    (rd_ctx)
    );

    // Ready only while idle
    assign req_ready = (st == ST_IDLE);
    // Next probe slot wraps by width
    assign nxt_slot  = cur_q + 1'b1;
    // Probe budget: 16, 32, 64 or 128
    assign limit     = CNT_W'(16) << search_lim;

    // Store write port: entry words or clear sweep
    always_comb begin
        we    = 1'b0;
        waddr = {cur_q, 1'b0};
        wdata = '0;
        case (st)
            ST_WR_H: begin
                we    = 1'b1;
                waddr = {cur_q, 1'b0};
                wdata = (op_q == OP_INSERT) ? handle_q : '0;
            end
            ST_WR_C: begin
                we    = 1'b1;
                waddr = {cur_q, 1'b1};
                wdata = (op_q == OP_INSERT) ? new_ctx : '0;
            end
            ST_CLEAR: begin
                we    = 1'b1;
                waddr = clr_addr;
            end
            default: ;
        endcase
    end

    // Command sequencing and response generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            op_q     <= OP_INSERT;
            handle_q <= '0;
            chan_q   <= '0;
            eng_q    <= '0;
            inst_q   <= '0;
            start_q  <= '0;
            cur_q    <= '0;
            cnt_q    <= '0;
            clr_addr <= '0;
            rsp_done <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_fail <= 1'b0;
            rsp_slot <= '0;
            rsp_ctx  <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_fail <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q     <= ht_op_t'(req_op);
                        handle_q <= req_handle;
                        chan_q   <= req_chan;
                        eng_q    <= req_engine;
                        inst_q   <= req_inst;
                        start_q  <= hash_slot;
                        cnt_q    <= '0;
                        clr_addr <= '0;
                        case (ht_op_t'(req_op))
                            OP_REMOVE: begin
                                cur_q <= req_slot;
                                st    <= ST_WR_H;
                            end
                            OP_CLEAR: st <= ST_CLEAR;
                            default: begin
                                cur_q <= hash_slot;
                                st    <= ST_PROBE;
                            end
                        endcase
                    end
                end
                ST_PROBE: begin
                    if (handle_q == '0) begin
                        st       <= ST_IDLE;
                        rsp_done <= 1'b1;
                        rsp_fail <= (op_q == OP_INSERT);
                        rsp_slot <= start_q;
                        rsp_ctx  <= '0;
                    end else if (op_q == OP_INSERT) begin
                        if (rd_handle == '0) begin
                            st <= ST_WR_H;
                        end else if (nxt_slot == start_q) begin
                            st       <= ST_IDLE;
                            rsp_done <= 1'b1;
                            rsp_fail <= 1'b1;
                            rsp_slot <= start_q;
                            rsp_ctx  <= '0;
                        end else begin
                            cur_q <= nxt_slot;
                        end
                    end else begin
                        if (rd_handle == '0) begin
                            st       <= ST_IDLE;
                            rsp_done <= 1'b1;
                            rsp_slot <= cur_q;
                            rsp_ctx  <= '0;
                        end else if (rd_handle == handle_q && rd_chan == chan_q) begin
                            st       <= ST_IDLE;
                            rsp_done <= 1'b1;
                            rsp_hit  <= 1'b1;
                            rsp_slot <= cur_q;
                            rsp_ctx  <= rd_ctx;
                        end else if ((cnt_q + 1'b1) == limit || nxt_slot == start_q) begin
                            st       <= ST_IDLE;
                            rsp_done <= 1'b1;
                            rsp_slot <= cur_q;
                            rsp_ctx  <= '0;
                        end else begin
                            cur_q <= nxt_slot;
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_WR_H: st <= ST_WR_C;
                ST_WR_C: begin
                    st       <= ST_IDLE;
                    rsp_done <= 1'b1;
                    rsp_slot <= cur_q;
                    rsp_ctx  <= (op_q == OP_INSERT) ? new_ctx : '0;
                end
                ST_CLEAR: begin
                    clr_addr <= clr_addr + 1'b1;
                    if (clr_addr == ADDR_W'(WORDS - 1)) begin
                        st       <= ST_IDLE;
                        rsp_done <= 1'b1;
                        rsp_slot <= '0;
                        rsp_ctx  <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/obj_hash_engine_chk.sv
// Protocol checker for obj_hash_engine, bound to every instance.
// Observes the ports only and tracks the accepted command itself.
module obj_hash_engine_chk #(
    parameter int HASH_BITS = 9
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_op,
    input logic [31:0] req_handle,
    input logic        rsp_done,
    input logic        rsp_hit,
    input logic        rsp_fail
);
    localparam int WORDS = 2 << HASH_BITS;

    logic        clr_active;
    logic [31:0] clr_cycles;
    logic [31:0] last_handle;

    // Track the accepted clear and the last accepted handle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_active  <= 1'b0;
            clr_cycles  <= '0;
            last_handle <= '0;
        end else begin
            if (req_valid && req_ready) begin
                clr_active  <= (req_op == 2'd3);
                clr_cycles  <= '0;
                last_handle <= req_handle;
            end else begin
                if (rsp_done) clr_active <= 1'b0;
                if (clr_active) clr_cycles <= clr_cycles + 1;
            end
        end
    end

    // R11
    hit_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fail));
    // R11
    flag_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_fail) |-> rsp_done);
    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R10
    clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active && !rsp_done) |-> !req_ready);
    // R10
    clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_active && rsp_done) |-> (clr_cycles == WORDS));
    // R4
    zero_never_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (last_handle != 32'd0));
endmodule

bind obj_hash_engine obj_hash_engine_chk #(.HASH_BITS(HASH_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_handle (req_handle),
    .rsp_done   (rsp_done),
    .rsp_hit    (rsp_hit),
    .rsp_fail   (rsp_fail)
);

// File: tb/sim_obj_hash_engine.sv
// Bench for obj_hash_engine on a 32-slot table; expected slots and context
// words are computed arithmetically from the requirements.
module sim_obj_hash_engine;
    localparam int HB    = 5;
    localparam int NSLOT = 1 << HB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [31:0]   req_handle = '0;
    logic [4:0]    req_chan = '0;
    logic [1:0]    req_engine = '0;
    logic [19:0]   req_inst = '0;
    logic [HB-1:0] req_slot = '0;
    logic          fmt_newer = 1'b0;
    logic [1:0]    search_lim = 2'd3;
    logic          rsp_done, rsp_hit, rsp_fail;
    logic [HB-1:0] rsp_slot;
    logic [31:0]   rsp_ctx;

    int checks = 0;
    int failures = 0;
    int lat;
    logic busy_bad;
    logic r_hit, r_fail;
    logic [HB-1:0] r_slot;
    logic [31:0] r_ctx;

    obj_hash_engine #(.HASH_BITS(HB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_handle(req_handle), .req_chan(req_chan),
        .req_engine(req_engine), .req_inst(req_inst), .req_slot(req_slot),
        .fmt_newer(fmt_newer), .search_lim(search_lim), .rsp_done(rsp_done),
        .rsp_hit(rsp_hit), .rsp_fail(rsp_fail), .rsp_slot(rsp_slot), .rsp_ctx(rsp_ctx)
    );

    always #2.5 clk = ~clk;

    function automatic logic [HB-1:0] exp_slot(input logic [31:0] h, input logic [4:0] ch);
        int f = 0;
        for (int i = 0; i < 32; i += HB) f = f ^ int'((h >> i) & (NSLOT - 1));
        f = f ^ ((int'(ch) << (HB - 4)) & (NSLOT - 1));
        return HB'(f);
    endfunction

    function automatic logic [31:0] exp_ctx(input logic md, input logic [4:0] ch,
                                            input logic [1:0] e, input logic [19:0] ia);
        if (md) return (32'(ch) << 23) | (32'(e) << 20) | 32'(ia >> 4);
        return 32'h8000_0000 | (32'(ch) << 24) | (32'(e) << 16) | 32'(ia >> 4);
    endfunction

    task automatic check(input string req, input logic ok, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                       input logic [1:0] e, input logic [19:0] ia, input logic [HB-1:0] sl);
        @(negedge clk);
        req_op = op; req_handle = h; req_chan = ch; req_engine = e;
        req_inst = ia; req_slot = sl; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_bad = 1'b0;
        while (!rsp_done && lat < 5000) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            lat++;
        end
        if (lat >= 5000) check("watchdog", 1'b0, 32'(lat), 32'd0);
        r_hit = rsp_hit; r_fail = rsp_fail; r_slot = rsp_slot; r_ctx = rsp_ctx;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] h, seed;
        logic [4:0] ch;
        logic [HB-1:0] es;
        repeat (3) @(negedge clk);
        // Reset state
        check("R11 reset ready", req_ready == 1'b1 && rsp_done == 1'b0, {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;

        // R10: clear duration and busy
        cmd(2'd3, 0, 0, 0, 0, 0);
        check("R10 clear latency", lat == 2 * NSLOT + 1, 32'(lat), 32'(2 * NSLOT + 1));
        check("R10 ready low in clear", !busy_bad, {31'd0, busy_bad}, 32'd0);

        // R1/R5/R6/R7/R9 sweep over handles, channels and both formats
        seed = 32'h1234_5679;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            h = seed | 32'd1;
            ch = 5'(i);
            fmt_newer = i[0];
            es = exp_slot(h, ch);
            cmd(2'd0, h, ch, 2'(i), 20'(seed >> 8), 0);
            check("R1 insert slot", r_slot == es && !r_fail, 32'(r_slot), 32'(es));
            check(i[0] ? "R6 ctx newer" : "R5 ctx legacy",
                  r_ctx == exp_ctx(i[0], ch, 2'(i), 20'(seed >> 8)), r_ctx,
                  exp_ctx(i[0], ch, 2'(i), 20'(seed >> 8)));
            cmd(2'd1, h, ch, 0, 0, 0);
            check("R7 lookup hit", r_hit && r_slot == es, {r_hit, 26'd0, r_slot}, {1'b1, 26'd0, es});
            cmd(2'd1, h, ch ^ 5'd1, 0, 0, 0);
            check("R7 wrong channel miss", !r_hit, {31'd0, r_hit}, 32'd0);
            cmd(2'd2, 0, 0, 0, 0, es);
            cmd(2'd1, h, ch, 0, 0, 0);
            check("R9 removed miss", !r_hit, {31'd0, r_hit}, 32'd0);
        end
        fmt_newer = 1'b0;

        // R4: zero handle
        cmd(2'd0, 0, 0, 0, 0, 0);
        check("R4 zero insert fail", r_fail, {31'd0, r_fail}, 32'd1);
        cmd(2'd1, 0, 0, 0, 0, 0);
        check("R4 zero lookup miss", !r_hit && !r_fail, {30'd0, r_hit, r_fail}, 32'd0);

        // R2: wrap from last slot to slot 0
        cmd(2'd0, 32'd31, 0, 0, 0, 0);
        check("R2 first at last slot", r_slot == HB'(NSLOT - 1), 32'(r_slot), 32'(NSLOT - 1));
        h = 32'd31 | (32'd3 << 5) | (32'd3 << 10);
        cmd(2'd0, h, 0, 0, 0, 0);
        check("R2 wrapped to slot 0", r_slot == 0 && !r_fail, 32'(r_slot), 32'd0);
        cmd(2'd1, h, 0, 0, 0, 0);
        check("R2 wrapped lookup", r_hit && r_slot == 0, {r_hit, 26'd0, r_slot}, 32'h8000_0000);

        // R3/R8: fill the table with handles that all hash to slot 0
        cmd(2'd3, 0, 0, 0, 0, 0);
        for (int k = 1; k <= NSLOT; k++) begin
            h = (k < NSLOT) ? (32'(k) | (32'(k) << 5)) : (32'd1 | (32'd1 << 10));
            cmd(2'd0, h, 0, 0, 0, 0);
            check("R2 fill slot", r_slot == HB'(k - 1) && !r_fail, 32'(r_slot), 32'(k - 1));
        end
        cmd(2'd0, 32'd2 | (32'd2 << 10), 0, 0, 0, 0);
        check("R3 full table fail", r_fail, {31'd0, r_fail}, 32'd1);
        search_lim = 2'd0;
        cmd(2'd1, 32'd16 | (32'd16 << 5), 0, 0, 0, 0);
        check("R8 hit on 16th probe", r_hit && r_slot == 15, {r_hit, 26'd0, r_slot}, {1'b1, 26'd0, 5'd15});
        cmd(2'd1, 32'd17 | (32'd17 << 5), 0, 0, 0, 0);
        check("R8 miss beyond limit", !r_hit, {31'd0, r_hit}, 32'd0);
        search_lim = 2'd1;
        cmd(2'd1, 32'd17 | (32'd17 << 5), 0, 0, 0, 0);
        check("R8 hit with limit 32", r_hit && r_slot == 16, {r_hit, 26'd0, r_slot}, {1'b1, 26'd0, 5'd16});
        search_lim = 2'd3;
        cmd(2'd1, 32'd3 | (32'd3 << 10), 0, 0, 0, 0);
        check("R8 full wrap miss", !r_hit && lat <= NSLOT + 2, 32'(lat), 32'(NSLOT + 2));

        // R9: freed slot is reused
        cmd(2'd2, 0, 0, 0, 0, 5'd5);
        cmd(2'd0, 32'd3 | (32'd3 << 10), 0, 0, 0, 0);
        check("R9 reuse removed slot", r_slot == 5 && !r_fail, 32'(r_slot), 32'd5);

        // R10: clear empties everything
        cmd(2'd3, 0, 0, 0, 0, 0);
        cmd(2'd1, 32'd1 | (32'd1 << 5), 0, 0, 0, 0);
        check("R10 cleared miss", !r_hit, {31'd0, r_hit}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule